// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block translates a 32-bit virtual address into a physical address for a small soft processor that uses 4 KB pages. Each request carries a virtual address, an access kind (read, write or instruction fetch) and the process identifier of the running task. The low bits of the virtual page number pick one set. Every way of that set is compared in parallel, and one cycle later the block returns a registered result: hit, physical address, the permission flags of the entry, and a fault flag.

Translation entries live in a tag array and a data array inside the block. The management logic that fills the arrays writes one entry per cycle through the write port. The block never walks page tables, raises exceptions or touches caches; it only reports what the stored entries say.

Top module: `tlb_lookup`

## Requirements
- R1: A request accepted on `lk_valid` produces `rs_valid` high exactly one clock later, and a cycle with no request produces `rs_valid` low one clock later; requests may be issued back to back.
- R2: The page number is `lk_vaddr[31:12]` and the set is the page number masked to log2(NUM_ENTRIES/NUM_WAYS) bits. A way matches only when its tag bits [31:12] equal the full page number, so a page that aliases to the same set does not hit.
- R3: Tag bit 11 (global) set makes an entry match whatever `lk_pid` is.
- R4: With tag bit 11 clear, an entry matches only when tag bits [PID_W-1:0] equal `lk_pid`.
- R5: When several ways of the set match, the lowest-numbered way supplies the result.
- R6: On a miss, `rs_hit`, `rs_paddr`, all flag outputs and `rs_fault` are zero.
- R7: On a hit, `rs_paddr` is data bits [19:0] (the frame number) shifted left by 12, so its low 12 bits are zero.
- R8: On a hit, `rs_cache`, `rs_read`, `rs_write` and `rs_exec` copy data bits 20, 21, 22 and 23 of the selected entry.
- R9: `rs_fault` is high exactly when the request hit and the flag for its kind is clear: kind 0 needs read, kind 1 needs write, kind 2 needs execute, and the reserved kind 3 always faults on a hit.
- R10: Tag bit 10 (valid) does not affect matching.
- R11: Reset clears every tag and data word to zero and drives all result outputs low.
- R12: A write through `wr_en` to way `wr_way`, set `wr_set` replaces that entry and is seen by any request issued after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe from the management logic |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | SET_W | Set to write |
| wr_tag | input | 32 | New tag word (page, global, valid, PID) |
| wr_data | input | 32 | New data word (frame, C, R, W, X) |
| lk_valid | input | 1 | Translation request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| lk_pid | input | PID_W | Current process identifier |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_hit | output | 1 | A way matched |
| rs_paddr | output | 32 | Translated page address |
| rs_cache | output | 1 | Cacheable flag of the hit entry |
| rs_read | output | 1 | Read permission of the hit entry |
| rs_write | output | 1 | Write permission of the hit entry |
| rs_exec | output | 1 | Execute permission of the hit entry |
| rs_fault | output | 1 | Hit without permission for the requested kind |

## Verification
The bench builds the block with two ways, eight entries and a 4-bit process identifier, which gives four sets. With two ways, both ways of one set can match a single request, so the lowest-way priority is exercised. The small set count makes aliasing easy to set up: pages 1 and 5 share set 1 and differ only in the upper page bits. A narrow PID keeps the PID compare and the global bypass visible, each decided by a single differing field.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int PFN_W      = 20;

  localparam int TAG_GLOBAL = 11;
  localparam int TAG_VALID  = 10;

  localparam int DAT_CACHE  = 20;
  localparam int DAT_READ   = 21;
  localparam int DAT_WRITE  = 22;
  localparam int DAT_EXEC   = 23;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  function automatic logic [VPN_W-1:0] page_of(input logic [31:0] addr);
    return addr[31:PAGE_SHIFT];
  endfunction

  function automatic logic tag_matches(input logic [31:0] tag,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic pid_equal);
    return (tag[31:PAGE_SHIFT] == vpn) && (tag[TAG_GLOBAL] || pid_equal);
  endfunction

  function automatic logic kind_allowed(input logic [1:0] kind,
                                        input logic [31:0] data);
    case (kind)
      KIND_READ:  return data[DAT_READ];
      KIND_WRITE: return data[DAT_WRITE];
      KIND_FETCH: return data[DAT_EXEC];
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] frame_addr(input logic [31:0] data);
    return {data[PFN_W-1:0], {PAGE_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [31:0]          wr_tag,
  input  logic [31:0]          wr_data,
  input  logic [SET_W-1:0]     rd_set,
  output logic [WAYS*32-1:0]   rd_tag,
  output logic [WAYS*32-1:0]   rd_data
);
  localparam int ENTRIES = WAYS * SETS;

  logic [31:0] tag_q  [ENTRIES];
  logic [31:0] data_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic entry_we;
    assign entry_we = wr_en && (wr_way == WAY_W'(e / SETS)) &&
                      (wr_set == SET_W'(e % SETS));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[e]  <= '0;
        data_q[e] <= '0;
      end else if (entry_we) begin
        tag_q[e]  <= wr_tag;
        data_q[e] <= wr_data;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_read
    assign rd_tag[w*32 +: 32]  = tag_q[w*SETS + int'(rd_set)];
    assign rd_data[w*32 +: 32] = data_q[w*SETS + int'(rd_set)];
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 4,
  parameter int PID_W = 8
) (
  input  logic [WAYS*32-1:0]          rd_tag,
  input  logic [tlb_pkg::VPN_W-1:0]   vpn,
  input  logic [PID_W-1:0]            pid,
  output logic [WAYS-1:0]             way_match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [31:0] tag;
    logic        pid_eq;
    logic        unused_bits;
    assign tag         = rd_tag[w*32 +: 32];
    assign pid_eq      = (tag[PID_W-1:0] == pid);
    assign unused_bits = ^tag[10:PID_W];
    assign way_match[w] = tlb_pkg::tag_matches(tag, vpn, pid_eq);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0] way_match,
  output logic [WAYS-1:0] way_grant
);
  always_comb begin
    logic found;
    found     = 1'b0;
    way_grant = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w] && !found) begin
        way_grant[w] = 1'b1;
        found        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int PID_W       = 8,
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [31:0]       wr_tag,
  input  logic [31:0]       wr_data,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic [1:0]        lk_kind,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [31:0]       rs_paddr,
  output logic              rs_cache,
  output logic              rs_read,
  output logic              rs_write,
  output logic              rs_exec,
  output logic              rs_fault
);
  import tlb_pkg::*;

  logic [VPN_W-1:0]       req_vpn;
  logic [SET_W-1:0]       req_set;
  logic [NUM_WAYS*32-1:0] set_tags;
  logic [NUM_WAYS*32-1:0] set_data;
  logic [NUM_WAYS-1:0]    way_match;
  logic [NUM_WAYS-1:0]    way_grant;
  logic [31:0]            hit_data;
  logic                   hit_now;
  logic                   fault_now;
  logic                   unused_data;

  assign req_vpn = page_of(lk_vaddr);
  assign req_set = SET_W'(req_vpn & VPN_W'(SETS - 1));

  tlb_store #(.WAYS(NUM_WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
    .wr_tag(wr_tag), .wr_data(wr_data),
    .rd_set(req_set), .rd_tag(set_tags), .rd_data(set_data)
  );

  tlb_match #(.WAYS(NUM_WAYS), .PID_W(PID_W)) u_match (
    .rd_tag(set_tags), .vpn(req_vpn), .pid(lk_pid), .way_match(way_match)
  );

  tlb_pick #(.WAYS(NUM_WAYS)) u_pick (
    .way_match(way_match), .way_grant(way_grant)
  );

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_grant[w]) hit_data = hit_data | set_data[w*32 +: 32];
    end
  end

  assign hit_now     = |way_match;
  assign fault_now   = hit_now && !kind_allowed(lk_kind, hit_data);
  assign unused_data = ^hit_data[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_paddr <= '0;
      rs_cache <= 1'b0;
      rs_read  <= 1'b0;
      rs_write <= 1'b0;
      rs_exec  <= 1'b0;
      rs_fault <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && hit_now;
      rs_paddr <= (lk_valid && hit_now) ? frame_addr(hit_data) : '0;
      rs_cache <= lk_valid && hit_now && hit_data[DAT_CACHE];
      rs_read  <= lk_valid && hit_now && hit_data[DAT_READ];
      rs_write <= lk_valid && hit_now && hit_data[DAT_WRITE];
      rs_exec  <= lk_valid && hit_now && hit_data[DAT_EXEC];
      rs_fault <= lk_valid && fault_now;
    end
  end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [1:0]      lk_kind,
  input logic            rs_valid,
  input logic            rs_hit,
  input logic [31:0]     rs_paddr,
  input logic            rs_cache,
  input logic            rs_read,
  input logic            rs_write,
  input logic            rs_exec,
  input logic            rs_fault,
  input logic [WAYS-1:0] way_match,
  input logic [WAYS-1:0] way_grant
);
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_grant) && ((way_grant & ~way_match) == '0));
  a_r5_lowest_way: assert property (@(posedge clk) disable iff (!rst_n)
    (|way_match) |-> ($onehot(way_grant) && (((way_grant - 1'b1) & way_match) == '0)));
  a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_paddr == '0 && !rs_cache && !rs_read &&
                               !rs_write && !rs_exec && !rs_fault));
  a_r7_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_paddr[11:0] == 12'h000));
  a_r9_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> (rs_valid && rs_hit));
  a_r9_read_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'd0) |=> (!rs_hit || (rs_fault != rs_read)));
  a_r9_write_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'd1) |=> (!rs_hit || (rs_fault != rs_write)));
  a_r9_fetch_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'd2) |=> (!rs_hit || (rs_fault != rs_exec)));
endmodule

bind tlb_lookup tlb_lookup_chk #(.WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_paddr(rs_paddr),
  .rs_cache(rs_cache), .rs_read(rs_read), .rs_write(rs_write),
  .rs_exec(rs_exec), .rs_fault(rs_fault),
  .way_match(way_match), .way_grant(way_grant)
);

// File: tb/tlb_lookup_test.sv
`timescale 1ns/1ps
module tlb_lookup_test;
  localparam int NW = 2, NE = 8, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [0:0] wr_way = '0;
  logic [1:0] wr_set = '0;
  logic [31:0] wr_tag = '0, wr_data = '0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0] lk_kind = '0;
  logic [PW-1:0] lk_pid = '0;
  logic rs_valid, rs_hit, rs_cache, rs_read, rs_write, rs_exec, rs_fault;
  logic [31:0] rs_paddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_lookup #(.NUM_WAYS(NW), .NUM_ENTRIES(NE), .PID_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
    .wr_tag(wr_tag), .wr_data(wr_data), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_pid(lk_pid), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_paddr(rs_paddr), .rs_cache(rs_cache), .rs_read(rs_read),
    .rs_write(rs_write), .rs_exec(rs_exec), .rs_fault(rs_fault)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] pack_res(input logic v, h, input logic [31:0] pa,
                                           input logic c, r, w, x, f);
    return {2'b0, v, h, pa, c, r, w, x, f};
  endfunction

  task automatic put(input int way, input int set, input logic [19:0] vpn,
                     input logic g, input logic v, input logic [PW-1:0] pid,
                     input logic [19:0] pfn, input logic c, r, w, x);
    @(negedge clk);
    wr_en = 1'b1; wr_way = 1'(way); wr_set = 2'(set);
    wr_tag  = {vpn, g, v, 6'b0, pid};
    wr_data = {8'h00, x, w, r, c, pfn};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ask(input string req, input logic [31:0] va, input logic [1:0] kind,
                     input logic [PW-1:0] pid, input logic h, input logic [19:0] pfn,
                     input logic c, r, w, x);
    logic perm;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_pid = pid;
    @(negedge clk);
    lk_valid = 1'b0;
    perm = (kind == 2'd0) ? r : (kind == 2'd1) ? w : (kind == 2'd2) ? x : 1'b0;
    check(req, pack_res(rs_valid, rs_hit, rs_paddr, rs_cache, rs_read, rs_write, rs_exec, rs_fault),
          h ? pack_res(1'b1, 1'b1, {pfn, 12'h000}, c, r, w, x, !perm)
            : pack_res(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_reset;
    check("R11 idle after reset", {39'b0, rs_valid}, 40'h0);
    ask("R11 cleared entry page0 pid0", 32'h0000_0010, 2'd0, 4'h0, 1'b1, 20'h0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    put(0, 1, 20'h00001, 0, 1, 4'h3, 20'hABCDE, 0, 1, 0, 1);
    ask("R7 R8 basic read hit", 32'h0000_1234, 2'd0, 4'h3, 1'b1, 20'hABCDE, 0, 1, 0, 1);
    ask("R9 write without permission", 32'h0000_1FFC, 2'd1, 4'h3, 1'b1, 20'hABCDE, 0, 1, 0, 1);
    ask("R9 fetch allowed", 32'h0000_1000, 2'd2, 4'h3, 1'b1, 20'hABCDE, 0, 1, 0, 1);
    ask("R9 reserved kind faults", 32'h0000_1000, 2'd3, 4'h3, 1'b1, 20'hABCDE, 0, 1, 0, 1);
  endtask

  task automatic t_pid;
    ask("R4 R6 other pid misses", 32'h0000_1234, 2'd0, 4'h4, 1'b0, 20'h0, 0, 0, 0, 0);
  endtask

  task automatic t_alias;
    ask("R2 aliasing page misses", 32'h0000_5234, 2'd0, 4'h3, 1'b0, 20'h0, 0, 0, 0, 0);
  endtask

  task automatic t_global;
    put(1, 2, 20'h12346, 1, 1, 4'h7, 20'h0F00F, 1, 1, 1, 0);
    ask("R3 global ignores pid", 32'h1234_6ABC, 2'd1, 4'h0, 1'b1, 20'h0F00F, 1, 1, 1, 0);
    ask("R8 R9 global fetch faults", 32'h1234_6000, 2'd2, 4'h9, 1'b1, 20'h0F00F, 1, 1, 1, 0);
  endtask

  task automatic t_priority;
    put(0, 3, 20'h00003, 0, 1, 4'h1, 20'h00111, 0, 1, 1, 1);
    put(1, 3, 20'h00003, 1, 1, 4'h0, 20'h00222, 1, 1, 0, 0);
    ask("R5 lowest way wins", 32'h0000_3000, 2'd0, 4'h1, 1'b1, 20'h00111, 0, 1, 1, 1);
    ask("R5 second way alone", 32'h0000_3000, 2'd0, 4'h2, 1'b1, 20'h00222, 1, 1, 0, 0);
  endtask

  task automatic t_valid_ignored;
    put(1, 0, 20'h00004, 0, 0, 4'h5, 20'h44444, 1, 0, 1, 0);
    ask("R10 valid bit ignored", 32'h0000_4008, 2'd1, 4'h5, 1'b1, 20'h44444, 1, 0, 1, 0);
  endtask

  task automatic t_overwrite;
    put(0, 1, 20'h00001, 0, 1, 4'h3, 20'h55555, 0, 0, 1, 0);
    ask("R12 rewritten entry", 32'h0000_1000, 2'd1, 4'h3, 1'b1, 20'h55555, 0, 0, 1, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h0000_3000; lk_kind = 2'd0; lk_pid = 4'h1;
    @(negedge clk);
    check("R1 first of pair", {7'b0, rs_valid, rs_paddr},
          {7'b0, 1'b1, 32'h0011_1000});
    lk_vaddr = 32'h1234_6000; lk_pid = 4'h2;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R1 second of pair", {7'b0, rs_valid, rs_paddr},
          {7'b0, 1'b1, 32'h0F00_F000});
    @(negedge clk);
    check("R1 idle after pair", {39'b0, rs_valid}, 40'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pid();
    t_alias();
    t_global();
    t_priority();
    t_valid_ignored();
    t_overwrite();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule